// File: doc/BRIEF.md
# Hiccup Overcurrent Fault Sequencer

This block is the digital fault manager of a multiphase buck controller. Analog comparators outside the block produce an overcurrent flag and an undervoltage flag. The block resynchronises both flags into its own clock domain and, while the converter is ramping or regulating, treats either flag as a fault event. On a fault it removes the switching enable at once and holds every power switch off for a fixed hiccup interval. It then asks the external ramp generator for a fresh soft-start.

Overcurrent and undervoltage events feed a single event counter. When the counter reaches its limit (three by default), the block stops for good and raises a fault output. Only the asynchronous power-on reset releases it from that state. The counter persists across successful restarts, so three faults spread over any number of hiccup cycles still end in shutdown.

Top module: `hiccup_fault_seq`

## Requirements
- R1: One clock edge after reset is released, the block enters soft-start. It drives `ss_req`=1 and `sw_en`=1 for exactly SS_CYCLES cycles, then enters run with `ss_req`=0 and `sw_en`=1.
- R2: Each fault flag passes through a synchronizer of SYNC_STAGES flops (default 2). A flag first sampled high at clock edge k removes `sw_en` in the cycle after edge k+1, with no further register delay.
- R3: After a fault event, `sw_en` and `ss_req` stay low for the event cycle plus exactly HICCUP_CYCLES cycles (default 2048), 2049 cycles in all. `ss_req` then rises to begin a new soft-start.
- R4: Faults are detected during soft-start as well as in run. A fault during the ramp drops `sw_en` and `ss_req` and starts another hiccup interval.
- R5: A fault flag that pulses during the hiccup wait has no effect. The wait keeps its length and the pulse is not counted.
- R6: Overcurrent and undervoltage events add to one counter. The FAULT_LIMIT-th event (default 3) moves the block to a latched stop with `fault_o`=1, `sw_en`=0 and `ss_req`=0.
- R7: Completing a soft-start and reaching run does not clear the event counter. Only reset clears it.
- R8: In the latched stop, fault-flag activity of any length never re-enables switching or soft-start, and `fault_o` stays high.
- R9: The asynchronous active-low reset `rst_n` clears all state at once, the latch included. While it is held low, all three outputs are low.
- R10: A fault flag held high counts once per shutdown. If the flag is still high when a new soft-start begins, that soft-start is a new event at once, with `ss_req` held low. A flag held high from run therefore latches after 4099 cycles with the defaults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| oc_flag | input | 1 | Overcurrent comparator output, asynchronous |
| uv_flag | input | 1 | Undervoltage comparator output, asynchronous |
| sw_en | output | 1 | Power switch drive enable |
| ss_req | output | 1 | Request to the soft-start ramp generator |
| fault_o | output | 1 | Permanent shutdown indicator |

## Verification
The bench keeps the hiccup interval at its full default of 2048 cycles, so the exact dwell is measured as a whole and not scaled down. It shortens soft-start to 40 cycles, which leaves room for faults inside the ramp, completed ramps between events, and a flag held across two full hiccup intervals in one short run. The fault limit stays at three and the synchronizer at two stages, so the 4099-cycle latch time for a held flag and the two-edge detection latency are checked at their real values.

// File: rtl/hfs_pkg.sv
`timescale 1ns/1ps
package hfs_pkg;
   typedef enum logic [2:0] {
      ST_RESET_WAIT,
      ST_SOFTSTART,
      ST_RUN,
      ST_HICCUP_WAIT,
      ST_LATCHED
   } hfs_state_e;
endpackage

// File: rtl/hfs_sync.sv
`timescale 1ns/1ps
// Multi-flop resynchronizer for one asynchronous level.
module hfs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hfs_timer.sv
`timescale 1ns/1ps
// Loadable down-counter shared by the soft-start and hiccup dwell phases.
module hfs_timer #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done,
   output logic [W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             count <= '0;
      else if (load)          count <= load_val;
      else if (count != '0)   count <= count - 1'b1;
   end

   assign done = (count == '0);
endmodule

// File: rtl/hfs_event_cnt.sv
`timescale 1ns/1ps
// Saturating fault-event counter, cleared only by reset.
module hfs_event_cnt #(
   parameter  int LIMIT = 3,
   localparam int CW    = $clog2(LIMIT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   output logic          last,
   output logic [CW-1:0] count
);
   localparam logic [CW-1:0] FULL     = CW'(LIMIT);
   localparam logic [CW-1:0] PENULT   = CW'(LIMIT - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    count <= '0;
      else if (inc && count != FULL) count <= count + 1'b1;
   end

   // The event being counted now is the one that reaches the limit.
   assign last = (count == PENULT);
endmodule

// File: rtl/hiccup_fault_seq.sv
`timescale 1ns/1ps
module hiccup_fault_seq #(
   parameter int HICCUP_CYCLES = 2048,
   parameter int SS_CYCLES     = 256,
   parameter int FAULT_LIMIT   = 3,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic oc_flag,
   input  logic uv_flag,
   output logic sw_en,
   output logic ss_req,
   output logic fault_o
);
   import hfs_pkg::*;

   localparam int N_SRC = 2;
   localparam int TMAX  = (HICCUP_CYCLES > SS_CYCLES) ? HICCUP_CYCLES : SS_CYCLES;
   localparam int TW    = $clog2(TMAX + 1);
   localparam int CW    = $clog2(FAULT_LIMIT + 1);
   localparam logic [TW-1:0] HIC_LOAD = TW'(HICCUP_CYCLES - 1);
   localparam logic [TW-1:0] SS_LOAD  = TW'(SS_CYCLES - 1);

   // Elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("hiccup_fault_seq: SYNC_STAGES must be at least 2");
   end
   if (HICCUP_CYCLES < 1) begin : g_bad_hic
      $error("hiccup_fault_seq: HICCUP_CYCLES must be at least 1");
   end
   if (SS_CYCLES < 1) begin : g_bad_ss
      $error("hiccup_fault_seq: SS_CYCLES must be at least 1");
   end
   if (FAULT_LIMIT < 1) begin : g_bad_lim
      $error("hiccup_fault_seq: FAULT_LIMIT must be at least 1");
   end

   // Fault flag resynchronization, one chain per source
   logic [N_SRC-1:0] raw_flag;
   logic [N_SRC-1:0] sync_flag;
   assign raw_flag = {uv_flag, oc_flag};

   for (genvar gi = 0; gi < N_SRC; gi++) begin : g_src
      hfs_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .d    (raw_flag[gi]),
         .q    (sync_flag[gi])
      );
   end

   logic sync_any;
   assign sync_any = |sync_flag;

   // Sequencer state
   hfs_state_e state_q, state_d;
   logic       active;
   logic       fault_evt;
   logic       tim_load;
   logic [TW-1:0] tim_val;
   logic [TW-1:0] tim_cnt;
   logic       tim_done;
   logic       evt_last;
   logic [CW-1:0] evt_cnt;

   assign active    = (state_q == ST_SOFTSTART) || (state_q == ST_RUN);
   assign fault_evt = active && sync_any;

   hfs_timer #(.W(TW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tim_load),
      .load_val(tim_val),
      .done    (tim_done),
      .count   (tim_cnt)
   );

   hfs_event_cnt #(.LIMIT(FAULT_LIMIT)) u_evt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (fault_evt),
      .last (evt_last),
      .count(evt_cnt)
   );

   always_comb begin
      state_d  = state_q;
      tim_load = 1'b0;
      tim_val  = SS_LOAD;
      unique case (state_q)
         ST_RESET_WAIT: begin
            state_d  = ST_SOFTSTART;
            tim_load = 1'b1;
         end
         ST_SOFTSTART, ST_RUN: begin
            if (fault_evt) begin
               if (evt_last) begin
                  state_d = ST_LATCHED;
               end else begin
                  state_d  = ST_HICCUP_WAIT;
                  tim_load = 1'b1;
                  tim_val  = HIC_LOAD;
               end
            end else if (state_q == ST_SOFTSTART && tim_done) begin
               state_d = ST_RUN;
            end
         end
         ST_HICCUP_WAIT: begin
            if (tim_done) begin
               state_d  = ST_SOFTSTART;
               tim_load = 1'b1;
            end
         end
         ST_LATCHED: state_d = ST_LATCHED;
         default:    state_d = ST_LATCHED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_RESET_WAIT;
      else        state_q <= state_d;
   end

   // Drive outputs drop in the same cycle the synchronized fault appears
   assign sw_en   = active && !sync_any;
   assign ss_req  = (state_q == ST_SOFTSTART) && !sync_any;
   assign fault_o = (state_q == ST_LATCHED);
endmodule

// File: rtl/hfs_checker.sv
`timescale 1ns/1ps
module hfs_checker #(
   parameter int FAULT_LIMIT = 3,
   parameter int TW = 12,
   parameter int CW = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sw_en,
   input logic               ss_req,
   input logic               fault_o,
   input logic               sync_any,
   input hfs_pkg::hfs_state_e state,
   input logic [TW-1:0]      tim,
   input logic [CW-1:0]      cnt
);
   import hfs_pkg::*;

   a_r1_ramp_needs_switching: assert property (@(posedge clk) disable iff (!rst_n)
      ss_req |-> sw_en);

   a_r3_hiccup_dwell: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HICCUP_WAIT && tim != '0) |=> (state == ST_HICCUP_WAIT));

   a_r3_hiccup_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HICCUP_WAIT && tim == '0) |=> (state == ST_SOFTSTART));

   a_r4_fault_leaves_active: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_any && (state == ST_SOFTSTART || state == ST_RUN))
      |=> (state == ST_HICCUP_WAIT || state == ST_LATCHED));

   a_r5_no_count_in_hiccup: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HICCUP_WAIT) |=> $stable(cnt));

   a_r6_latched_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> (!sw_en && !ss_req));

   a_r6_latch_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LATCHED) |-> (cnt == CW'(FAULT_LIMIT)));

   a_r7_count_never_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |=> (cnt >= $past(cnt)));

   a_r8_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |=> fault_o);
endmodule

bind hiccup_fault_seq hfs_checker #(
   .FAULT_LIMIT(FAULT_LIMIT),
   .TW(TW),
   .CW(CW)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sw_en   (sw_en),
   .ss_req  (ss_req),
   .fault_o (fault_o),
   .sync_any(sync_any),
   .state   (state_q),
   .tim     (tim_cnt),
   .cnt     (evt_cnt)
);

// File: tb/tb_hiccup_fault_seq.sv
`timescale 1ns/1ps
module tb_hiccup_fault_seq;
   localparam int HIC = 2048;
   localparam int SS  = 40;
   localparam int LIM = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic oc_flag = 1'b0;
   logic uv_flag = 1'b0;
   logic sw_en, ss_req, fault_o;

   always #4 clk = ~clk;   // 125 MHz

   hiccup_fault_seq #(
      .HICCUP_CYCLES(HIC),
      .SS_CYCLES(SS),
      .FAULT_LIMIT(LIM),
      .SYNC_STAGES(2)
   ) dut (
      .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag), .uv_flag(uv_flag),
      .sw_en(sw_en), .ss_req(ss_req), .fault_o(fault_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   task automatic chk(input string req, input logic act, input logic exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic chk_int(input string req, input int act, input int exp, input string what);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // Behavioural reference: phase code, dwell left, events so far, sample history
   // phases: 0 after reset, 1 ramp, 2 regulating, 3 hiccup, 4 stopped
   int m_ph, m_left, m_events;
   int m_hist[$];
   int m_seen;
   bit m_trig;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_left = 0; m_events = 0;
         m_hist.delete();
      end else begin
         m_seen = (m_hist.size() > 1) ? m_hist[1] : 0;
         m_trig = (m_ph == 1 || m_ph == 2) && (m_seen != 0);
         if (m_trig) begin
            m_events++;
            if (m_events >= LIM) m_ph = 4;
            else begin m_ph = 3; m_left = HIC - 1; end
         end else begin
            case (m_ph)
               0: begin m_ph = 1; m_left = SS - 1; end
               1: if (m_left == 0) m_ph = 2; else m_left--;
               3: if (m_left == 0) begin m_ph = 1; m_left = SS - 1; end
                  else m_left--;
               default: ;
            endcase
         end
         m_hist.push_front(int'(oc_flag | uv_flag));
         if (m_hist.size() > 3) void'(m_hist.pop_back());
      end
   end

   int e_seen;
   string e_tag;
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         e_seen = (m_hist.size() > 1) ? m_hist[1] : 0;
         case (m_ph)
            3: e_tag = "R3/R5";
            4: e_tag = "R6/R8";
            default: e_tag = (e_seen != 0) ? "R2/R4" : "R1/R7";
         endcase
         chk(e_tag, sw_en,  (m_ph == 1 || m_ph == 2) && e_seen == 0, "model sw_en");
         chk(e_tag, ss_req, (m_ph == 1) && e_seen == 0, "model ss_req");
         chk(e_tag, fault_o, m_ph == 4, "model fault_o");
      end
   end

   task automatic tick(input int k);
      repeat (k) @(negedge clk);
   endtask

   // Count cycles with switching off, starting at the fault cycle, until ramp resumes
   task automatic count_off(input int inject, output int n);
      n = 0;
      while (!ss_req && !fault_o && n < 10000) begin
         if (!sw_en) n++;
         if (n == inject) uv_flag = 1'b1;
         if (n == inject + 1) uv_flag = 1'b0;
         @(negedge clk);
      end
   endtask

   initial begin
      int n;
      bit seen;
      tick(3);
      // R9 reset state
      chk("R9", sw_en, 1'b0, "sw_en in reset");
      chk("R9", ss_req, 1'b0, "ss_req in reset");
      chk("R9", fault_o, 1'b0, "fault_o in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", ss_req, 1'b1, "ramp starts after reset");
      n = 0;
      while (ss_req && n < 1000) begin n++; @(negedge clk); end
      chk_int("R1", n, SS, "soft-start length");
      chk("R1", sw_en, 1'b1, "run enables switching");
      tick(5);

      // Event 1: overcurrent pulse in run, with undervoltage pulse in hiccup
      @(negedge clk) oc_flag = 1'b1;
      @(negedge clk) oc_flag = 1'b0;
      chk("R2", sw_en, 1'b1, "still on one edge after sampling");
      @(negedge clk);
      chk("R2", sw_en, 1'b0, "off two edges after sampling");
      count_off(100, n);
      chk_int("R3", n, HIC + 1, "hiccup off time incl. fault cycle");
      chk_int("R5", n, HIC + 1, "hiccup not extended by pulse");
      chk("R3", ss_req, 1'b1, "ramp resumes");

      // Event 2: undervoltage pulse during soft-start
      tick(5);
      @(negedge clk) uv_flag = 1'b1;
      @(negedge clk) uv_flag = 1'b0;
      @(negedge clk);
      chk("R4", sw_en, 1'b0, "ramp fault removes switching");
      chk("R4", ss_req, 1'b0, "ramp fault removes request");
      chk("R5", fault_o, 1'b0, "hiccup pulse not counted");
      count_off(-5, n);
      chk_int("R3", n, HIC + 1, "second hiccup length");
      n = 0;
      while (ss_req && n < 1000) begin n++; @(negedge clk); end
      chk("R7", sw_en, 1'b1, "ramp completed to run");
      tick(10);

      // Event 3 after a completed ramp: must latch
      @(negedge clk) oc_flag = 1'b1;
      @(negedge clk) oc_flag = 1'b0;
      @(negedge clk);
      chk("R6", fault_o, 1'b0, "not latched in fault cycle");
      @(negedge clk);
      chk("R6", fault_o, 1'b1, "third mixed event latches");
      chk("R7", fault_o, 1'b1, "count kept across run");

      // R8: activity while latched
      seen = 1'b0;
      oc_flag = 1'b1; uv_flag = 1'b1;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (i == 1000) oc_flag = 1'b0;
         if (i == 2000) uv_flag = 1'b0;
         if (i == 2500) oc_flag = 1'b1;
         if (sw_en || ss_req || !fault_o) seen = 1'b1;
      end
      oc_flag = 1'b0;
      chk("R8", seen, 1'b0, "latched state disturbed");

      // R9: asynchronous reset mid-cycle clears the latch
      @(negedge clk);
      #2 rst_n = 1'b0;
      #1;
      chk("R9", fault_o, 1'b0, "latch cleared by async reset");
      chk("R9", sw_en, 1'b0, "sw_en low in reset");
      tick(3);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", ss_req, 1'b1, "restart after reset");
      n = 0;
      while (ss_req && n < 1000) begin n++; @(negedge clk); end
      chk_int("R1", n, SS, "soft-start length after reset");
      tick(5);

      // R10: flag held high from run
      oc_flag = 1'b1;
      n = 0;
      while (sw_en && n < 100) begin n++; @(negedge clk); end
      n = 0; seen = 1'b0;
      while (!fault_o && n < 10000) begin
         @(negedge clk);
         n++;
         if (ss_req) seen = 1'b1;
      end
      chk_int("R10", n, 2 * HIC + 3, "held flag latch time");
      chk("R10", seen, 1'b0, "no ramp request while flag held");
      oc_flag = 1'b0;
      tick(3);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule